// File: doc/BRIEF.md
# Quad-Pumped Strobe-Pair Data Receiver

This receiver captures a 64-bit source-synchronous data bus that transfers four beats in every common bus clock period. The bus is split into four 16-bit lanes. Each lane has its own pair of complementary strobes, a "positive" and a "negative" strobe. A lane is latched on every falling edge of either strobe of its pair. Beats alternate between the two strobes and begin with the positive strobe. Each beat of each lane also carries an inversion flag. When the flag is set, the lane's bits were sent complemented, and the receiver restores them before storing them.

Every lane keeps its own bank of beat registers for each strobe. A free-running edge counter selects the slot that each edge writes. At every common clock edge the receiver samples those counters. From the counter values it works out which slots hold the four beats of the period that has just ended, and whether each strobe fell exactly twice. When the data-ready input was high for that period, the four beats are packed into a 256-bit word. The word is presented with a one-cycle valid pulse. An error pulse is raised beside the word if any lane saw a wrong number of strobe edges.

Top module: `qp_strobe_rx`

## Requirements
- R1: While reset is asserted (rst_n low), word_out is all zeros and word_valid and edge_err are 0.
- R2: Beat k of a period (k = 0..3) appears at word_out[64k+63:64k]. Beats 0 and 2 are taken on the first and second falling edges of the positive strobe. Beats 1 and 3 are taken on the first and second falling edges of the negative strobe.
- R3: Strobe pair g (strb_p[g], strb_n[g]) captures only lane g, which is bus_data[16g+15:16g]. Lane g of beat k lands at word_out[64k+16g+15:64k+16g].
- R4: A lane latched while its inv_flag bit is 1 is stored bit-complemented. A lane latched with the flag at 0 is stored unchanged. The flag applies per lane and per beat.
- R5: If data_rdy is high at a rising clk edge, word_valid is high for exactly the following clock cycle and word_out holds the period's word.
- R6: If data_rdy is low at a rising clk edge, word_valid stays low and word_out is unchanged, even when the strobes toggled during that period.
- R7: edge_err is raised together with word_valid when, in that data-ready period, either strobe of any lane fell a number of times other than two.
- R8: After a period with a wrong edge count, the next period with correct strobes yields a correct word with edge_err low.
- R9: Data-ready periods that follow each other with no gap each produce their own correct word in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 64 | Source-synchronous data lanes, 16 bits per lane |
| inv_flag | input | 4 | Per-lane inversion flag, one bit per lane, travels with the data |
| strb_p | input | 4 | Positive strobe for each lane, latches on its falling edge |
| strb_n | input | 4 | Negative strobe for each lane, latches on its falling edge |
| data_rdy | input | 1 | Driver's data-ready for the current clock period |
| word_out | output | 256 | Assembled four-beat word |
| word_valid | output | 1 | One-cycle pulse marking a new word |
| edge_err | output | 1 | Pulse beside word_valid when a lane's edge count was wrong |

## Verification
The hardest case to reach from the ports is slot misalignment. This happens when one lane's strobe loses or gains an edge, so that lane's counter parity no longer matches the others. The receiver must flag that period and still decode the next one. The bench creates this by suppressing the second positive-strobe fall on a single lane, and by adding a stray negative-strobe pulse on another lane, and then sends a clean random word. It also toggles all strobes during a period with data-ready low, which moves every counter without producing a word. The next word then has to be decoded from shifted slots.

// File: rtl/qp_rx_pkg.sv
package qp_rx_pkg;
   // default geometry of the receiver
   localparam int unsigned LANE_W_DEF  = 16;
   localparam int unsigned LANES_DEF   = 4;
   localparam int unsigned BEATS_DEF   = 4;

   // number of beats latched by each strobe of a pair
   function automatic int unsigned beats_per_strobe(input int unsigned beats);
      return beats / 2;
   endfunction
endpackage

// File: rtl/qp_edge_bank.sv
// One strobe of one lane: latches the lane on each falling strobe edge
// into a rotating slot and counts the edges.
module qp_edge_bank #(
   parameter int unsigned LANE_W = 16,
   parameter int unsigned SLOTS  = 2,
   parameter int unsigned CNT_W  = 3
) (
   input  logic                          rst_n,
   input  logic                          strobe,
   input  logic [LANE_W-1:0]             lane_in,
   input  logic                          lane_inv,
   output logic [CNT_W-1:0]              edge_cnt,
   output logic [SLOTS-1:0][LANE_W-1:0]  slot_q
);
   localparam int unsigned SLW = $clog2(SLOTS);

   logic [LANE_W-1:0] lane_plain;
   assign lane_plain = lane_in ^ {LANE_W{lane_inv}};

   always_ff @(negedge strobe or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
         slot_q   <= '0;
      end else begin
         slot_q[edge_cnt[SLW-1:0]] <= lane_plain;
         edge_cnt                  <= edge_cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/qp_lane_retime.sv
// Common-clock side of one lane: remembers the edge counters seen at the
// previous clock, picks the period's beats out of the slots and checks
// that each strobe fell exactly SLOTS times.
module qp_lane_retime #(
   parameter int unsigned LANE_W = 16,
   parameter int unsigned SLOTS  = 2,
   parameter int unsigned CNT_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [CNT_W-1:0]              cnt_p,
   input  logic [CNT_W-1:0]              cnt_n,
   input  logic [SLOTS-1:0][LANE_W-1:0]  slot_p,
   input  logic [SLOTS-1:0][LANE_W-1:0]  slot_n,
   output logic [2*SLOTS-1:0][LANE_W-1:0] beats,
   output logic                          count_bad
);
   localparam int unsigned SLW = $clog2(SLOTS);

   logic [CNT_W-1:0] base_p, base_n;
   logic [CNT_W-1:0] span_p, span_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_p <= '0;
         base_n <= '0;
      end else begin
         base_p <= cnt_p;
         base_n <= cnt_n;
      end
   end

   assign span_p    = cnt_p - base_p;
   assign span_n    = cnt_n - base_n;
   assign count_bad = (span_p != CNT_W'(SLOTS)) || (span_n != CNT_W'(SLOTS));

   always_comb begin
      for (int j = 0; j < SLOTS; j++) begin
         beats[2*j]   = slot_p[SLW'(base_p[SLW-1:0] + SLW'(j))];
         beats[2*j+1] = slot_n[SLW'(base_n[SLW-1:0] + SLW'(j))];
      end
   end
endmodule

// File: rtl/qp_strobe_rx.sv
module qp_strobe_rx
   import qp_rx_pkg::*;
#(
   parameter int unsigned LANE_W = LANE_W_DEF,
   parameter int unsigned LANES  = LANES_DEF,
   parameter int unsigned BEATS  = BEATS_DEF
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [LANE_W*LANES-1:0]         bus_data,
   input  logic [LANES-1:0]                inv_flag,
   input  logic [LANES-1:0]                strb_p,
   input  logic [LANES-1:0]                strb_n,
   input  logic                            data_rdy,
   output logic [BEATS*LANE_W*LANES-1:0]   word_out,
   output logic                            word_valid,
   output logic                            edge_err
);
   localparam int unsigned BUS_W  = LANE_W * LANES;
   localparam int unsigned WORD_W = BEATS * BUS_W;
   localparam int unsigned SLOTS  = beats_per_strobe(BEATS);
   localparam int unsigned CNT_W  = $clog2(SLOTS) + 2;

   generate
      if (BEATS < 4 || (BEATS % 2) != 0)
         $error("BEATS must be even and at least 4");
      if ((SLOTS & (SLOTS - 1)) != 0)
         $error("BEATS/2 must be a power of two");
      if (LANE_W == 0 || LANES == 0)
         $error("LANE_W and LANES must be nonzero");
   endgenerate

   logic [BEATS-1:0][LANE_W-1:0] lane_beats [LANES];
   logic                         lane_bad   [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [CNT_W-1:0]             cnt_p, cnt_n;
      logic [SLOTS-1:0][LANE_W-1:0] slot_p, slot_n;

      qp_edge_bank #(.LANE_W(LANE_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_bank_p (
         .rst_n    (rst_n),
         .strobe   (strb_p[g]),
         .lane_in  (bus_data[g*LANE_W +: LANE_W]),
         .lane_inv (inv_flag[g]),
         .edge_cnt (cnt_p),
         .slot_q   (slot_p)
      );

      qp_edge_bank #(.LANE_W(LANE_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_bank_n (
         .rst_n    (rst_n),
         .strobe   (strb_n[g]),
         .lane_in  (bus_data[g*LANE_W +: LANE_W]),
         .lane_inv (inv_flag[g]),
         .edge_cnt (cnt_n),
         .slot_q   (slot_n)
      );

      qp_lane_retime #(.LANE_W(LANE_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_retime (
         .clk       (clk),
         .rst_n     (rst_n),
         .cnt_p     (cnt_p),
         .cnt_n     (cnt_n),
         .slot_p    (slot_p),
         .slot_n    (slot_n),
         .beats     (lane_beats[g]),
         .count_bad (lane_bad[g])
      );
   end

   logic [WORD_W-1:0] word_nxt;
   logic              any_bad;

   always_comb begin
      word_nxt = '0;
      any_bad  = 1'b0;
      for (int g = 0; g < LANES; g++) begin
         any_bad = any_bad | lane_bad[g];
         for (int k = 0; k < BEATS; k++)
            word_nxt[k*BUS_W + g*LANE_W +: LANE_W] = lane_beats[g][k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_out   <= '0;
         word_valid <= 1'b0;
         edge_err   <= 1'b0;
      end else begin
         word_valid <= data_rdy;
         edge_err   <= data_rdy & any_bad;
         if (data_rdy)
            word_out <= word_nxt;
      end
   end
endmodule

// File: rtl/qp_strobe_rx_chk.sv
module qp_strobe_rx_chk #(
   parameter int unsigned W = 256
) (
   input logic         clk,
   input logic         rst_n,
   input logic         data_rdy,
   input logic         word_valid,
   input logic         edge_err,
   input logic [W-1:0] word_out
);
   a_r5_valid_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      data_rdy |=> word_valid);

   a_r6_no_valid_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !data_rdy |=> !word_valid);

   a_r6_word_held_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !data_rdy |=> $stable(word_out));

   a_r7_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      edge_err |-> word_valid);
endmodule

bind qp_strobe_rx qp_strobe_rx_chk #(.W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .data_rdy   (data_rdy),
   .word_valid (word_valid),
   .edge_err   (edge_err),
   .word_out   (word_out)
);

// File: tb/qp_strobe_rx_test.sv
`timescale 1ns/1ps
module qp_strobe_rx_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [63:0]  bus_data = '0;
   logic [3:0]   inv_flag = '0;
   logic [3:0]   strb_p = 4'hF;
   logic [3:0]   strb_n = 4'hF;
   logic         data_rdy = 1'b0;
   logic [255:0] word_out;
   logic         word_valid;
   logic         edge_err;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   qp_strobe_rx uut (
      .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .inv_flag(inv_flag),
      .strb_p(strb_p), .strb_n(strb_n), .data_rdy(data_rdy),
      .word_out(word_out), .word_valid(word_valid), .edge_err(edge_err)
   );

   function automatic logic [255:0] rand_word();
      logic [255:0] w;
      for (int i = 0; i < 8; i++) w[32*i +: 32] = $urandom;
      return w;
   endfunction

   task automatic put_beat(input logic [255:0] w, input logic [15:0] inv, input int k);
      for (int g = 0; g < 4; g++) begin
         bus_data[16*g +: 16] = w[64*k + 16*g +: 16] ^ {16{inv[4*k+g]}};
         inv_flag[g]          = inv[4*k+g];
      end
   endtask

   // Drives one clock period starting just after a rising clk edge.
   // skip_g: lanes whose second positive-strobe fall is suppressed.
   // extra_g: lanes that get an extra negative-strobe pulse at the end.
   task automatic drive_period(input logic [255:0] w, input logic [15:0] inv,
                               input logic [3:0] skip_g, input logic [3:0] extra_g,
                               input logic rdy);
      #1   data_rdy = rdy; put_beat(w, inv, 0);
      #1   strb_p = 4'h0;
      #1   strb_p = 4'hF; put_beat(w, inv, 1);
      #1   strb_n = 4'h0;
      #1   strb_n = 4'hF; put_beat(w, inv, 2);
      #1   strb_p = skip_g;
      #1   strb_p = 4'hF; put_beat(w, inv, 3);
      #1   strb_n = 4'h0;
      #0.5 strb_n = 4'hF;
      #0.5 strb_n = ~extra_g;
      #0.5 strb_n = 4'hF;
   endtask

   task automatic check_bit(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", what, act, exp);
      end
   endtask

   task automatic check_word(input logic [255:0] exp, input string what);
      checks++;
      if (word_out !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, word_out, exp);
      end
   endtask

   // One data-ready period, then checks the result and the single pulse.
   task automatic send_and_check(input logic [255:0] w, input logic [15:0] inv,
                                 input logic [3:0] skip_g, input logic [3:0] extra_g,
                                 input logic exp_err, input logic chk_word, input string tag);
      @(posedge clk);
      drive_period(w, inv, skip_g, extra_g, 1'b1);
      @(posedge clk);
      #1 data_rdy = 1'b0;
      #3;
      check_bit(word_valid, 1'b1, {tag, " R5 valid"});
      check_bit(edge_err, exp_err, {tag, " R7 edge_err"});
      if (chk_word) check_word(w, {tag, " word"});
      @(posedge clk);
      #4;
      check_bit(word_valid, 1'b0, {tag, " R5 single pulse"});
      check_bit(edge_err, 1'b0, {tag, " R7 err single pulse"});
   endtask

   task automatic t_reset();
      #12;
      check_word('0, "R1 word at reset");
      check_bit(word_valid, 1'b0, "R1 valid at reset");
      check_bit(edge_err, 1'b0, "R1 err at reset");
      #5 rst_n = 1'b1;
   endtask

   task automatic t_order_lanes();
      logic [255:0] w;
      for (int k = 0; k < 4; k++)
         for (int g = 0; g < 4; g++)
            w[64*k + 16*g +: 16] = {4'hA, 4'(k), 4'h5, 4'(g)};
      send_and_check(w, 16'h0000, 4'h0, 4'h0, 1'b0, 1'b1, "R2 R3 tagged beats");
      send_and_check(rand_word(), 16'h0000, 4'h0, 4'h0, 1'b0, 1'b1, "R2 random");
   endtask

   task automatic t_inversion();
      send_and_check(rand_word(), 16'hFFFF, 4'h0, 4'h0, 1'b0, 1'b1, "R4 all inverted");
      send_and_check(rand_word(), 16'hA5C3, 4'h0, 4'h0, 1'b0, 1'b1, "R4 mixed flags");
      send_and_check(rand_word(), 16'($urandom), 4'h0, 4'h0, 1'b0, 1'b1, "R4 random flags");
   endtask

   task automatic t_idle_strobes();
      logic [255:0] held;
      @(posedge clk);
      #4 held = word_out;
      @(posedge clk);
      drive_period(rand_word(), 16'h0F0F, 4'h0, 4'h0, 1'b0);
      @(posedge clk);
      #4;
      check_bit(word_valid, 1'b0, "R6 no valid when idle");
      check_word(held, "R6 word held when idle");
      send_and_check(rand_word(), 16'h3C3C, 4'h0, 4'h0, 1'b0, 1'b1, "R6 word after idle strobes");
   endtask

   task automatic t_faults();
      send_and_check(rand_word(), 16'h0000, 4'h2, 4'h0, 1'b1, 1'b0, "R7 missing edge lane1");
      send_and_check(rand_word(), 16'h1248, 4'h0, 4'h0, 1'b0, 1'b1, "R8 recovery after missing");
      send_and_check(rand_word(), 16'h0000, 4'h0, 4'h8, 1'b1, 1'b0, "R7 extra edge lane3");
      send_and_check(rand_word(), 16'h8421, 4'h0, 4'h0, 1'b0, 1'b1, "R8 recovery after extra");
   endtask

   task automatic t_back_to_back();
      logic [255:0] ws [3];
      logic [15:0]  iv [3];
      for (int i = 0; i < 3; i++) begin
         ws[i] = rand_word();
         iv[i] = 16'($urandom);
      end
      @(posedge clk);
      drive_period(ws[0], iv[0], 4'h0, 4'h0, 1'b1);
      for (int i = 1; i < 3; i++) begin
         @(posedge clk);
         fork
            drive_period(ws[i], iv[i], 4'h0, 4'h0, 1'b1);
            begin
               #4;
               check_bit(word_valid, 1'b1, "R9 back-to-back valid");
               check_word(ws[i-1], "R9 back-to-back word");
            end
         join
      end
      @(posedge clk);
      #1 data_rdy = 1'b0;
      #3;
      check_bit(word_valid, 1'b1, "R9 last valid");
      check_word(ws[2], "R9 last word");
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_order_lanes();
            t_inversion();
            t_idle_strobes();
            t_faults();
            t_back_to_back();
         end
         begin
            #(200000 * 10);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule